// File: doc/BRIEF.md
# Serial-Tap Decimating Complex FIR

This block filters a stream of complex samples (separate I and Q words) and lowers their rate by an integer factor M. It runs on a processing clock that is much faster than the sample rate. Each path has a single multiplier, and that multiplier evaluates one tap per clock. Input samples arrive with a one-cycle valid strobe and are shifted into a history line. Once in every M accepted samples, a sweep begins. The sweep walks the programmed number of taps, reads one coefficient per cycle from an external coefficient RAM with a one-cycle read latency, and accumulates the products. The finished I and Q results are presented with a one-cycle valid pulse.

Several coefficient sets can share the RAM. A base offset picks which set is used, and its value is captured when a sweep starts, so it can be changed at any time without corrupting an output in progress. In the folded (symmetric) mode only half of the impulse response is stored. The read index reflects at the midpoint, so each stored word serves two taps, and up to 128 taps can be computed from a 64-word set. A phase word picks which sample within each group of M starts a sweep. Several instances fed with the same stream can therefore cover the branches of a polyphase decomposition. The filter length must not exceed the number of fast clocks available per output, less one.

Top module: `dec_fir_engine`

## Requirements
- R1: After reset `out_valid` is 0, `out_i` and `out_q` are 0, the accepted-sample counter is 0 and every history entry is 0, so early outputs see zero for samples before the first one.
- R2: A counter advances by one on each `in_valid` and wraps after `cfg_decim_m1` (M−1). An accepted sample starts a sweep when the counter value it meets equals `cfg_phase`, so one sweep starts per M samples, beginning with sample number `cfg_phase` after reset.
- R3: A sweep of N = `cfg_ntaps_m1`+1 taps takes one clock per tap. If the triggering sample is sampled at clock edge t, `out_valid` is high for exactly one cycle, after edge t+N+1.
- R4: With `cfg_sym`=0 the output is y[n] = Σ_{k=0}^{N−1} h[k]·x[n−k], where x[n] is the triggering sample and h[k] is read from address (`cfg_coef_ofs`+N−1−k) mod 64. The coefficients are stored in reverse order.
- R5: With `cfg_sym`=1, S = ceil(N/2) words are used. Tap k takes j = k for k < S and j = N−1−k otherwise, and reads address (`cfg_coef_ofs`+S−1−j) mod 64. N may be as large as 128.
- R6: Offset, tap count and mode are captured when a sweep starts. Changing them during a sweep affects only later outputs.
- R7: Samples accepted during a sweep enter the history without changing the result of the sweep in progress.
- R8: A start condition that occurs while a sweep is still issuing taps is dropped and produces no output. The sample counter still advances.
- R9: The accumulator is signed and wide enough that 128 full-scale products sum exactly. For example, 128·(−32768)·(−32768) = 2^37.
- R10: The I and Q paths use the same coefficients and are computed independently and in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | One-cycle strobe marking a new input sample |
| in_i | input | DW | Signed in-phase input sample |
| in_q | input | DW | Signed quadrature input sample |
| cfg_decim_m1 | input | DECW | Decimation factor M minus one |
| cfg_phase | input | DECW | Counter value on which a sweep starts |
| cfg_ntaps_m1 | input | TAPW | Tap count minus one |
| cfg_sym | input | 1 | 1 selects folded (symmetric) coefficient addressing |
| cfg_coef_ofs | input | CAW | Base address of the coefficient set |
| coef_addr | output | CAW | Coefficient RAM read address |
| coef_data | input | CW | Coefficient RAM read data, one cycle after the address |
| out_valid | output | 1 | One-cycle pulse marking a finished output |
| out_i | output | ACCW | Signed in-phase result, held until the next output |
| out_q | output | ACCW | Signed quadrature result, held until the next output |

## Verification
The main function is tried with several stimulus patterns:
- An asymmetric short filter with random data and distinct I/Q streams. Because the bench predicts the exact output cycle, this exposes a reversed coefficient order, swapped paths or a shifted sample alignment.
- A non-zero phase word with a shifted base offset, which separates the trigger choice from the addressing.
- Folded filters of odd length and of the full 128 taps. These tell a correct reflection at the midpoint from an off-by-one mirror.
- An offset flipped mid-sweep, and a dense stream with M=1 where samples arrive during sweeps and most starts are dropped. These distinguish capture at sweep start from live configuration, and a compensated history index from one that slips.
- All-full-scale data, which detects a truncated accumulator.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

  typedef enum logic {
    SWEEP_IDLE = 1'b0,
    SWEEP_RUN  = 1'b1
  } sweep_state_e;

  localparam int PATHS = 2;

endpackage

// File: rtl/dfe_phase_ctr.sv
module dfe_phase_ctr #(
  parameter int DECW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DECW-1:0] decim_m1,
  input  logic [DECW-1:0] phase,
  output logic            trig
);

  logic [DECW-1:0] cnt_q;
  logic [DECW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (in_valid) begin
      if (cnt_q >= decim_m1) cnt_d = '0;
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign trig = in_valid && (cnt_q == phase);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/dfe_history.sv
module dfe_history #(
  parameter int DW     = 16,
  parameter int HDEPTH = 144,
  parameter int HIW    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic signed [DW-1:0] din,
  input  logic [HIW-1:0]       sel_idx,
  output logic signed [DW-1:0] sel_data
);

  logic signed [DW-1:0] line_q [HDEPTH];
  logic signed [DW-1:0] line_d [HDEPTH];

  always_comb begin
    line_d = line_q;
    if (shift_en) begin
      line_d[0] = din;
      for (int i = 1; i < HDEPTH; i++) line_d[i] = line_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HDEPTH; i++) line_q[i] <= '0;
    end else begin
      line_q <= line_d;
    end
  end

  always_comb begin
    sel_data = '0;
    for (int i = 0; i < HDEPTH; i++) begin
      if (sel_idx == HIW'(i)) sel_data = line_q[i];
    end
  end

endmodule

// File: rtl/dfe_sweep_ctl.sv
module dfe_sweep_ctl
  import dfe_pkg::*;
#(
  parameter int TAPW   = 7,
  parameter int CAW    = 6,
  parameter int HIW    = 8,
  parameter int HDEPTH = 144
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic            in_valid,
  input  logic [TAPW-1:0] ntaps_m1,
  input  logic            sym,
  input  logic [CAW-1:0]  ofs,
  output logic            busy,
  output logic            iss_valid,
  output logic            iss_first,
  output logic            iss_last,
  output logic [CAW-1:0]  coef_addr,
  output logic [HIW-1:0]  hist_idx
);

  localparam int AW = TAPW + CAW + 1;

  sweep_state_e    st_q, st_d;
  logic [TAPW-1:0] k_q, k_d;
  logic [HIW-1:0]  sh_q, sh_d;
  logic [TAPW-1:0] nm1_q, nm1_d;
  logic            sym_q, sym_d;
  logic [CAW-1:0]  ofs_q, ofs_d;

  logic            start;
  logic            running;
  logic            at_last;
  logic [AW-1:0]   n_w, s_w, k_w, j_w, addr_w;

  assign running = (st_q == SWEEP_RUN);
  assign start   = trig && !running;
  assign at_last = running && (k_q == nm1_q);

  always_comb begin
    st_d  = st_q;
    k_d   = k_q;
    sh_d  = sh_q;
    nm1_d = nm1_q;
    sym_d = sym_q;
    ofs_d = ofs_q;
    if (start) begin
      st_d  = SWEEP_RUN;
      k_d   = '0;
      sh_d  = '0;
      nm1_d = ntaps_m1;
      sym_d = sym;
      ofs_d = ofs;
    end else if (running) begin
      if (in_valid) sh_d = sh_q + 1'b1;
      if (at_last) st_d = SWEEP_IDLE;
      else         k_d  = k_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SWEEP_IDLE;
      k_q   <= '0;
      sh_q  <= '0;
      nm1_q <= '0;
      sym_q <= 1'b0;
      ofs_q <= '0;
    end else begin
      st_q  <= st_d;
      k_q   <= k_d;
      sh_q  <= sh_d;
      nm1_q <= nm1_d;
      sym_q <= sym_d;
      ofs_q <= ofs_d;
    end
  end

  always_comb begin
    n_w = AW'(nm1_q) + AW'(1);
    s_w = (n_w + AW'(1)) >> 1;
    k_w = AW'(k_q);
    if (sym_q && (k_w >= s_w)) j_w = n_w - AW'(1) - k_w;
    else                       j_w = k_w;
    if (sym_q) addr_w = AW'(ofs_q) + s_w - AW'(1) - j_w;
    else       addr_w = AW'(ofs_q) + n_w - AW'(1) - k_w;
  end

  assign coef_addr = addr_w[CAW-1:0];
  assign hist_idx  = HIW'(k_q) + sh_q;
  assign busy      = running;
  assign iss_valid = running;
  assign iss_first = running && (k_q == '0);
  assign iss_last  = at_last;

  AST_TAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (k_q <= nm1_q)); // R3
  AST_MIRROR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sym_q) |-> (j_w < s_w)); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> ($stable(ofs_q) && $stable(nm1_q) && $stable(sym_q))); // R6
  AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (hist_idx < HIW'(HDEPTH))); // R7

endmodule

// File: rtl/dfe_mac.sv
module dfe_mac #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int ACCW = 39
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   first,
  input  logic                   last,
  input  logic signed [CW-1:0]   coef,
  input  logic signed [DW-1:0]   smp,
  output logic signed [ACCW-1:0] y
);

  localparam int PW = DW + CW;

  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] base;
  logic signed [ACCW-1:0] acc_q, acc_d;
  logic signed [ACCW-1:0] y_q, y_d;
  logic signed [ACCW:0]   sum_wide;

  assign prod = coef * smp;
  assign base = first ? '0 : acc_q;

  always_comb begin
    acc_d = acc_q;
    y_d   = y_q;
    if (en) begin
      acc_d = base + {{(ACCW-PW){prod[PW-1]}}, prod};
      if (last) y_d = acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      y_q   <= '0;
    end else begin
      acc_q <= acc_d;
      y_q   <= y_d;
    end
  end

  assign y = y_q;

  assign sum_wide = {base[ACCW-1], base} + {{(ACCW+1-PW){prod[PW-1]}}, prod};

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (sum_wide[ACCW] == sum_wide[ACCW-1])); // R9

endmodule

// File: rtl/dec_fir_engine.sv
module dec_fir_engine
  import dfe_pkg::*;
#(
  parameter int DW         = 16,
  parameter int CW         = 16,
  parameter int MAX_TAPS   = 128,
  parameter int MAX_DEC    = 16,
  parameter int COEF_DEPTH = 64,
  localparam int TAPW   = $clog2(MAX_TAPS),
  localparam int DECW   = $clog2(MAX_DEC),
  localparam int CAW    = $clog2(COEF_DEPTH),
  localparam int ACCW   = DW + CW + TAPW,
  localparam int HDEPTH = MAX_TAPS + MAX_DEC,
  localparam int HIW    = $clog2(HDEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [DW-1:0]   in_i,
  input  logic signed [DW-1:0]   in_q,
  input  logic [DECW-1:0]        cfg_decim_m1,
  input  logic [DECW-1:0]        cfg_phase,
  input  logic [TAPW-1:0]        cfg_ntaps_m1,
  input  logic                   cfg_sym,
  input  logic [CAW-1:0]         cfg_coef_ofs,
  output logic [CAW-1:0]         coef_addr,
  input  logic signed [CW-1:0]   coef_data,
  output logic                   out_valid,
  output logic signed [ACCW-1:0] out_i,
  output logic signed [ACCW-1:0] out_q
);

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic           trig;
  logic           busy;
  logic           iss_valid, iss_first, iss_last;
  logic [HIW-1:0] hist_idx;

  dfe_phase_ctr #(.DECW(DECW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_ni),
    .in_valid (in_valid),
    .decim_m1 (cfg_decim_m1),
    .phase    (cfg_phase),
    .trig     (trig)
  );

  dfe_sweep_ctl #(.TAPW(TAPW), .CAW(CAW), .HIW(HIW), .HDEPTH(HDEPTH)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_ni),
    .trig      (trig),
    .in_valid  (in_valid),
    .ntaps_m1  (cfg_ntaps_m1),
    .sym       (cfg_sym),
    .ofs       (cfg_coef_ofs),
    .busy      (busy),
    .iss_valid (iss_valid),
    .iss_first (iss_first),
    .iss_last  (iss_last),
    .coef_addr (coef_addr),
    .hist_idx  (hist_idx)
  );

  logic p_valid_q, p_first_q, p_last_q;
  logic p_valid_d, p_first_d, p_last_d;
  logic ov_q, ov_d;

  always_comb begin
    p_valid_d = iss_valid;
    p_first_d = iss_first;
    p_last_d  = iss_last;
    ov_d      = p_valid_q && p_last_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      p_valid_q <= 1'b0;
      p_first_q <= 1'b0;
      p_last_q  <= 1'b0;
      ov_q      <= 1'b0;
    end else begin
      p_valid_q <= p_valid_d;
      p_first_q <= p_first_d;
      p_last_q  <= p_last_d;
      ov_q      <= ov_d;
    end
  end

  logic signed [DW-1:0]   path_in  [PATHS];
  logic signed [ACCW-1:0] path_out [PATHS];

  assign path_in[0] = in_i;
  assign path_in[1] = in_q;

  for (genvar p = 0; p < PATHS; p++) begin : g_path
    logic signed [DW-1:0] sel;
    logic signed [DW-1:0] smp_q, smp_d;

    dfe_history #(.DW(DW), .HDEPTH(HDEPTH), .HIW(HIW)) u_hist (
      .clk      (clk),
      .rst_n    (rst_ni),
      .shift_en (in_valid),
      .din      (path_in[p]),
      .sel_idx  (hist_idx),
      .sel_data (sel)
    );

    always_comb begin
      smp_d = smp_q;
      if (iss_valid) smp_d = sel;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) smp_q <= '0;
      else         smp_q <= smp_d;
    end

    dfe_mac #(.DW(DW), .CW(CW), .ACCW(ACCW)) u_mac (
      .clk   (clk),
      .rst_n (rst_ni),
      .en    (p_valid_q),
      .first (p_first_q),
      .last  (p_last_q),
      .coef  (coef_data),
      .smp   (smp_q),
      .y     (path_out[p])
    );
  end

  assign out_valid = ov_q;
  assign out_i     = path_out[0];
  assign out_q     = path_out[1];

  AST_ONE_CYCLE_OUT: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |=> !out_valid); // R3
  AST_SWEEP_TO_OUT: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy) |=> out_valid); // R3
  AST_DROP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    (trig && busy && !iss_last) |=> busy); // R8

endmodule

// File: tb/dec_fir_engine_test.sv
module dec_fir_engine_test;

  localparam int DW = 16, CW = 16, TAPW = 7, DECW = 4, CAW = 6, ACCW = 39;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [DW-1:0] in_i, in_q;
  logic [DECW-1:0] cfg_decim_m1, cfg_phase;
  logic [TAPW-1:0] cfg_ntaps_m1;
  logic cfg_sym;
  logic [CAW-1:0] cfg_coef_ofs;
  logic [CAW-1:0] coef_addr;
  logic signed [CW-1:0] coef_data;
  logic out_valid;
  logic signed [ACCW-1:0] out_i, out_q;

  always #10ns clk = ~clk;

  dec_fir_engine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .cfg_decim_m1(cfg_decim_m1), .cfg_phase(cfg_phase), .cfg_ntaps_m1(cfg_ntaps_m1),
    .cfg_sym(cfg_sym), .cfg_coef_ofs(cfg_coef_ofs), .coef_addr(coef_addr),
    .coef_data(coef_data), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  logic signed [CW-1:0] mem [64];
  always @(posedge clk) coef_data <= mem[coef_addr];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit mon_on = 0, done = 0;

  int xi [0:1023];
  int xq [0:1023];
  int nsamp, bcnt, busy_until;

  int     e_cyc [0:255];
  longint e_i   [0:255];
  longint e_q   [0:255];
  string  e_tag [0:255];
  int wr, rd;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int coef_of(int k);
    int n = cfg_ntaps_m1 + 1;
    int s = (n + 1) / 2;
    int j;
    if (cfg_sym) begin
      j = (k < s) ? k : n - 1 - k;
      return mem[(cfg_coef_ofs + s - 1 - j) % 64];
    end
    return mem[(cfg_coef_ofs + n - 1 - k) % 64];
  endfunction

  task automatic predict(int idx, int t, string tag);
    int n = cfg_ntaps_m1 + 1;
    longint si = 0, sq = 0;
    for (int k = 0; k < n; k++) begin
      if (idx - k >= 0) begin
        si += longint'(coef_of(k)) * xi[idx-k];
        sq += longint'(coef_of(k)) * xq[idx-k];
      end
    end
    e_cyc[wr] = t + n + 1; e_i[wr] = si; e_q[wr] = sq; e_tag[wr] = tag;
    wr++;
    busy_until = t + n;
  endtask

  // drive one sample for one cycle; the bench model decides whether it starts a sweep (R2, R8)
  task automatic send(int vi, int vq, string tag);
    int t;
    @(negedge clk);
    in_valid = 1'b1; in_i = DW'(vi); in_q = DW'(vq);
    @(posedge clk); #1;
    t = cyc;
    xi[nsamp] = vi; xq[nsamp] = vq;
    if (bcnt == cfg_phase && t > busy_until) predict(nsamp, t, tag);
    nsamp++;
    bcnt = (bcnt >= cfg_decim_m1) ? 0 : bcnt + 1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (rd < wr) begin
          check({e_tag[rd], " out cycle"}, cyc, e_cyc[rd]);
          check({e_tag[rd], " out_i"}, out_i, e_i[rd]);
          check({e_tag[rd], " out_q R10"}, out_q, e_q[rd]);
          rd++;
        end else check("R8 unexpected out_valid", 1, 0);
      end else if (rd < wr && cyc > e_cyc[rd]) begin
        check({e_tag[rd], " missing output"}, 0, 1);
        rd++;
      end
    end
  end

  task automatic do_reset(int m1, int ph, int nm1, bit sy, int ofs);
    mon_on = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
    cfg_decim_m1 = DECW'(m1); cfg_phase = DECW'(ph);
    cfg_ntaps_m1 = TAPW'(nm1); cfg_sym = sy; cfg_coef_ofs = CAW'(ofs);
    nsamp = 0; bcnt = 0; busy_until = -1; wr = 0; rd = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    mon_on = 1;
  endtask

  task automatic finish_scn(string tag, int tail);
    idle(tail);
    check({tag, " output count"}, rd, wr);
  endtask

  task automatic t_reset();
    do_reset(3, 0, 15, 0, 0);
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 out_i after reset", out_i, 0);
    check("R1 out_q after reset", out_q, 0);
  endtask

  task automatic t_asym();
    for (int a = 0; a < 64; a++) mem[a] = CW'(a * 37 - 900);
    do_reset(3, 0, 15, 0, 0);
    for (int s = 0; s < 24; s++) begin
      send($urandom_range(0, 4000) - 2000, $urandom_range(0, 4000) - 2000, "R4 R1 asym");
      idle(11);
    end
    finish_scn("R2 asym", 30);
  endtask

  task automatic t_phase();
    do_reset(3, 3, 9, 0, 20);
    for (int s = 0; s < 20; s++) begin
      send(s * 100 + 7, -s * 50 - 3, "R2 phase3");
      idle(11);
    end
    finish_scn("R2 phase3", 30);
  endtask

  task automatic t_sym_odd();
    for (int a = 0; a < 64; a++) mem[a] = CW'((a % 7) * 311 - 1000 + a);
    do_reset(1, 1, 8, 1, 59);
    for (int s = 0; s < 16; s++) begin
      send($urandom_range(0, 60000) - 30000, $urandom_range(0, 60000) - 30000, "R5 sym N9");
      idle(9);
    end
    finish_scn("R5 sym N9", 30);
  endtask

  task automatic t_ofs_switch();
    for (int a = 0; a < 32; a++) mem[a] = CW'(a + 1);
    for (int a = 32; a < 64; a++) mem[a] = CW'(-500 * (a - 31));
    do_reset(1, 0, 7, 0, 0);
    for (int s = 0; s < 16; s++) begin
      send(s * 13 - 90, 1000 - s * 41, "R6 ofs switch");
      idle(2);
      if (s % 2 == 0) begin
        cfg_coef_ofs = cfg_coef_ofs ^ CAW'(32);
        cfg_sym = ~cfg_sym;
      end
      idle(18);
    end
    finish_scn("R6 ofs switch", 30);
  endtask

  task automatic t_busy();
    for (int a = 0; a < 64; a++) mem[a] = CW'(a * 53 - 1700);
    do_reset(0, 0, 19, 0, 5);
    for (int s = 0; s < 40; s++) begin
      send(s * 211 - 4000, 3000 - s * 97, "R7 R8 busy");
      idle(2);
    end
    finish_scn("R8 busy", 40);
  endtask

  task automatic t_fullscale();
    for (int a = 0; a < 64; a++) mem[a] = -16'sd32768;
    do_reset(0, 0, 127, 1, 0);
    for (int s = 0; s < 130; s++) begin
      send(-32768, 32767, "R9 fullscale");
      idle(139);
    end
    finish_scn("R9 fullscale", 140);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 64; a++) mem[a] = '0;
    t_reset();
    t_asym();
    t_phase();
    t_sym_odd();
    t_ofs_switch();
    t_busy();
    t_fullscale();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule